// File: doc/BRIEF.md
# Time-Slot Timebase Capture Client

This block listens to a shared, time-multiplexed timebase bus. In each bus cycle a server places a 24-bit timebase word on the bus together with a 4-bit slot number and a valid strobe. The client compares the slot number with a slot-select value. When they match, it registers a 16-bit window of the word as the local timebase.

The window is chosen by a 2-bit select: the low 16 bits, the bits shifted right by 4, or the top 16 bits. While other slots pass, or while the bus is idle, the output keeps its last value. A one-cycle update pulse marks each cycle in which a fresh value appears.

A change to the slot select affects only the slots sampled after it. It never rewrites the value already held.

Top module: `tbc_client`

## Requirements
- R1: While rst_ni is low, and after reset until the first matching slot, tb_o is 0 and tb_upd_o is 0.
- R2: When bus_vld_i is 1 and bus_slot_i equals slot_sel_i at a rising clock edge, tb_o shows the selected window of bus_data_i and tb_upd_o is 1 from that edge on, for one cycle.
- R3: When bus_vld_i is 1 and bus_slot_i differs from slot_sel_i, tb_o keeps its value and tb_upd_o is 0 after the edge.
- R4: When bus_vld_i is 0, tb_o keeps its value and tb_upd_o is 0 after the edge, whatever the slot number.
- R5: win_sel_i = 0 selects bus_data_i[15:0].
- R6: win_sel_i = 1 selects bus_data_i[19:4].
- R7: win_sel_i = 2 selects bus_data_i[23:8]; the unused code 3 also selects bus_data_i[23:8].
- R8: A new slot_sel_i value leaves the captured tb_o unchanged. The new slot is captured the next time it appears.
- R9: Matches on consecutive edges give tb_upd_o high on consecutive cycles. tb_upd_o drops in the cycle after the last match.
- R10: Every slot number from 0 to 15 can be selected, including both end values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_vld_i | input | 1 | The bus carries a slot this cycle |
| bus_slot_i | input | 4 | Slot number on the bus |
| bus_data_i | input | 24 | Timebase word on the bus |
| slot_sel_i | input | 4 | Slot the client captures |
| win_sel_i | input | 2 | Bit window taken from the 24-bit word |
| tb_o | output | 16 | Registered local timebase |
| tb_upd_o | output | 1 | High in the cycle a new tb_o value appears |

## Verification
Words with distinct hex digits are applied under each window code. This makes a shift by the wrong amount, or a reversed mapping, give a visibly different 16-bit result.

Three cases are alternated around a matching slot: a non-matching slot, an idle bus that still carries the selected slot number, and a changed select that no longer matches. This separates a design that ignores the valid strobe from one that compares the wrong field.

Slot numbers 0 and 15 are selected to catch a truncated compare. Back-to-back matches show that the pulse is level-correct rather than edge-detected.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned TB_W   = 24;
  localparam int unsigned OUT_W  = 16;
  localparam int unsigned STEP   = 4;
  localparam int unsigned WSEL_W = 2;
  localparam int unsigned NUM_WIN = (TB_W - OUT_W) / STEP + 1;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [TB_W-1:0]   tb_word_t;
  typedef logic [OUT_W-1:0]  tb_out_t;
endpackage

// File: rtl/tbc_slot_match.sv
module tbc_slot_match #(
  parameter int unsigned SLOT_W = tbc_pkg::SLOT_W
) (
  input  logic              vld_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] sel_i,
  output logic              hit_o
);
  logic [SLOT_W-1:0] bit_eq;

  for (genvar b = 0; b < SLOT_W; b++) begin : g_bit
    assign bit_eq[b] = ~(slot_i[b] ^ sel_i[b]);
  end

  assign hit_o = vld_i & (&bit_eq);
endmodule

// File: rtl/tbc_window_mux.sv
module tbc_window_mux #(
  parameter int unsigned TB_W   = tbc_pkg::TB_W,
  parameter int unsigned OUT_W  = tbc_pkg::OUT_W,
  parameter int unsigned STEP   = tbc_pkg::STEP,
  parameter int unsigned WSEL_W = tbc_pkg::WSEL_W
) (
  input  logic [TB_W-1:0]   data_i,
  input  logic [WSEL_W-1:0] sel_i,
  output logic [OUT_W-1:0]  win_o
);
  localparam int unsigned NUM_WIN = (TB_W - OUT_W) / STEP + 1;

  logic [OUT_W-1:0] wins [NUM_WIN];

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    assign wins[k] = data_i[k*STEP +: OUT_W];
  end

  // out-of-range codes saturate to the top window
  always_comb begin
    win_o = wins[NUM_WIN-1];
    for (int k = 0; k < NUM_WIN; k++) begin
      if (int'(sel_i) == k) win_o = wins[k];
    end
  end
endmodule

// File: rtl/tbc_client.sv
module tbc_client
  import tbc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_vld_i,
  input  logic [SLOT_W-1:0] bus_slot_i,
  input  logic [TB_W-1:0]   bus_data_i,
  input  logic [SLOT_W-1:0] slot_sel_i,
  input  logic [WSEL_W-1:0] win_sel_i,
  output logic [OUT_W-1:0]  tb_o,
  output logic              tb_upd_o
);
  logic    hit;
  tb_out_t win;
  tb_out_t tb_q;
  logic    upd_q;

  tbc_slot_match #(.SLOT_W(SLOT_W)) u_match (
    .vld_i  (bus_vld_i),
    .slot_i (bus_slot_i),
    .sel_i  (slot_sel_i),
    .hit_o  (hit)
  );

  tbc_window_mux #(
    .TB_W(TB_W), .OUT_W(OUT_W), .STEP(STEP), .WSEL_W(WSEL_W)
  ) u_win (
    .data_i (bus_data_i),
    .sel_i  (win_sel_i),
    .win_o  (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_q  <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= hit;
      if (hit) tb_q <= win;
    end
  end

  assign tb_o     = tb_q;
  assign tb_upd_o = upd_q;

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_vld_i && bus_slot_i == slot_sel_i) |=> tb_upd_o);

  p_hold_other_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> ($stable(tb_o) && !tb_upd_o));

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_vld_i |=> !tb_upd_o);

  p_win_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && win_sel_i == 2'd0) |=> tb_o == $past(bus_data_i[15:0]));

  p_win_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && win_sel_i == 2'd1) |=> tb_o == $past(bus_data_i[19:4]));

  p_win_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && win_sel_i[1]) |=> tb_o == $past(bus_data_i[23:8]));

  p_no_upd_no_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tb_upd_o |-> $stable(tb_o));
endmodule

// File: tb/sim_tbc_client.sv
module sim_tbc_client;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {vld, slot, sel, win, data, exp_upd, exp_tb}
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 4'd3,  4'd3,  2'd0, 24'hABCDEF, 1'b1, 16'hCDEF}, // R2 R5
    {1'b1, 4'd4,  4'd3,  2'd0, 24'h123456, 1'b0, 16'hCDEF}, // R3
    {1'b0, 4'd3,  4'd3,  2'd1, 24'h123456, 1'b0, 16'hCDEF}, // R4
    {1'b1, 4'd3,  4'd3,  2'd1, 24'h123456, 1'b1, 16'h2345}, // R6
    {1'b1, 4'd3,  4'd3,  2'd2, 24'h789ABC, 1'b1, 16'h789A}, // R7
    {1'b1, 4'd3,  4'd3,  2'd3, 24'h13579B, 1'b1, 16'h1357}, // R7
    {1'b1, 4'd3,  4'd9,  2'd0, 24'hFFFFFF, 1'b0, 16'h1357}, // R8
    {1'b1, 4'd9,  4'd9,  2'd0, 24'h2468AC, 1'b1, 16'h68AC}, // R8
    {1'b1, 4'd0,  4'd0,  2'd0, 24'h000001, 1'b1, 16'h0001}, // R10
    {1'b1, 4'd15, 4'd15, 2'd2, 24'hFEDCBA, 1'b1, 16'hFEDC}, // R10
    {1'b1, 4'd15, 4'd15, 2'd2, 24'h0F1E2D, 1'b1, 16'h0F1E}, // R9
    {1'b0, 4'd15, 4'd15, 2'd2, 24'h555555, 1'b0, 16'h0F1E}  // R9
  };
  localparam string VREQ [NV] = '{"R2/R5", "R3", "R4", "R6", "R7", "R7",
                                  "R8", "R8", "R10", "R10", "R9", "R9"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_vld_i = 1'b0;
  logic [3:0]  bus_slot_i = '0;
  logic [23:0] bus_data_i = '0;
  logic [3:0]  slot_sel_i = '0;
  logic [1:0]  win_sel_i = '0;
  logic [15:0] tb_o;
  logic        tb_upd_o;
  int n_chk = 0;
  int n_err = 0;

  tbc_client u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic upd, input logic [15:0] tb);
    n_chk++;
    if (tb_upd_o !== upd || tb_o !== tb) begin
      n_err++;
      $display("FAIL %s: got upd=%b tb=%h, expected upd=%b tb=%h",
               req, tb_upd_o, tb_o, upd, tb);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] s, input logic [3:0] sel,
                       input logic [1:0] w, input logic [23:0] d);
    bus_vld_i = v; bus_slot_i = s; slot_sel_i = sel; win_sel_i = w; bus_data_i = d;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0, 16'h0000);  // in reset
    rst_ni = 1'b1;
    drive(1'b1, 4'd5, 4'd3, 2'd0, 24'hAAAAAA);
    check("R1", 1'b0, 16'h0000);  // no match yet

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][51], VEC[i][50:47], VEC[i][46:43], VEC[i][42:41], VEC[i][40:17]);
      check(VREQ[i], VEC[i][16], VEC[i][15:0]);
    end

    // R8: select change alone leaves captured value
    drive(1'b0, 4'd0, 4'd7, 2'd0, 24'h000000);
    check("R8", 1'b0, 16'h0F1E);

    // R1: mid-run reset clears, then stays zero
    rst_ni = 1'b0;
    #1;
    check("R1", 1'b0, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 4'd7, 4'd7, 2'd0, 24'h123456);
    check("R1", 1'b0, 16'h0000);
    drive(1'b1, 4'd7, 4'd7, 2'd1, 24'hC0FFEE);
    check("R2", 1'b1, 16'h0FFE);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule